// File: doc/BRIEF.md
# Clocked Serial Pattern Generator Channel

This block drives a short serial bit pattern onto a data line, together with a clock line that it generates itself. The pattern is 1 to 64 bits long. It is sent a programmed number of times, and the block then emits a single-cycle completion pulse. A parent that needs several independent channels instantiates the block once per channel.

The channel captures its configuration in the cycle in which it first sees `enable` high while idle. That configuration is the clock polarity, the 32-bit divider ratio, the pattern, the length-minus-one and the repetitions-minus-one. The configuration inputs are then ignored until `enable` is cleared.

Each half-period of the generated clock lasts `divRatio + 1` system cycles. Each pattern bit spans one full clock period: first a half at the inactive level, then a half at the active level. The data line changes only when the clock returns to its inactive level.

Top module: `pattern_channel`

## Requirements
- R1: After reset, `patClk`, `patData` and `donePulse` are all 0, with `polarity` held at 0.
- R2: In the cycle after the one in which `enable` is sampled high while idle, the run begins. Each half-period of `patClk` then lasts exactly `divRatio + 1` system cycles, and each bit starts with its inactive half.
- R3: The inactive level of `patClk` equals the polarity bit. With polarity 0 the clock rises mid-bit and the data changes on its falling edge. With polarity 1 the clock falls mid-bit and the data changes on its rising edge.
- R4: Bits go out least significant first, starting at `pattern[0]`. Bit 32, which is bit 0 of the upper 32-bit word, immediately follows bit 31.
- R5: `lenM1` holds the length minus one. A value of 0 sends 1 bit and a value of 63 sends all 64 bits. After the last bit the pattern restarts from bit 0.
- R6: `repsM1` holds the repetition count minus one. A value of 0 sends the pattern once and a value of 1023 sends it 1024 times.
- R7: `donePulse` is high for exactly one cycle. That cycle directly follows the final half-period of the last repetition. From that cycle on, `patClk` sits at its inactive level and `patData` is 0.
- R8: While `enable` stays high, changes to `polarity`, `divRatio`, `pattern`, `lenM1` or `repsM1` have no effect on the outputs.
- R9: Clearing `enable` aborts a run. In the next cycle `patData` is 0, `patClk` equals the `polarity` input, and no done pulse is emitted.
- R10: After a run completes, holding `enable` high does not start a new run. The outputs stay idle until `enable` is cleared and set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; a rise while idle starts a run |
| polarity | input | 1 | Inactive level of the pattern clock |
| divRatio | input | 32 | Half-period length minus one, in system cycles |
| pattern | input | 64 | Pattern bits; bit 0 is sent first |
| lenM1 | input | 6 | Pattern length minus one |
| repsM1 | input | 10 | Repetition count minus one |
| patClk | output | 1 | Generated pattern clock |
| patData | output | 1 | Serial pattern data |
| donePulse | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps divider ratios 0 to 2, both polarities, repetition counts 1 to 3, and lengths of 1, 2, 3, 32, 33 and 64 bits. Each run uses a different pseudo-random pattern, so a bit-order, wrap-point or word-boundary error shows up as a data mismatch in a predictable cycle. The ratio sweep separates half-period counting errors from bit-advance errors. The polarity sweep shows whether data moves on the correct clock edge. Further runs with 1024 repetitions, scrambled configuration inputs mid-run, an abort, and an enable held high after completion cover the boundary of the count field, the configuration freeze and the restart rule.

// File: rtl/pattern_channel_pkg.sv
package pattern_channel_pkg;

  typedef enum logic [1:0] {
    ChIdle = 2'd0,
    ChRun  = 2'd1,
    ChDone = 2'd2
  } chState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture configuration, rewind counters
    logic step;    // end of a bit period: advance to next bit
    logic finish;  // step that closes the last repetition
  } chStrobe_t;

endpackage

// File: rtl/pattern_channel_ctrl.sv
module pattern_channel_ctrl
  import pattern_channel_pkg::*;
#(
  parameter int DivW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic [DivW-1:0] ratio,
  input  logic            lastBit,
  input  logic            lastRep,
  output chStrobe_t       stb,
  output logic            idle,
  output logic            running,
  output logic            phase,
  output logic            donePulse
);

  chState_e        state;
  logic [DivW-1:0] divCnt;
  logic            halfEnd;

  assign halfEnd    = (divCnt == ratio);
  assign idle       = (state == ChIdle);
  assign running    = (state == ChRun);
  assign stb.load   = enable && idle;
  assign stb.step   = enable && running && halfEnd && phase;
  assign stb.finish = stb.step && lastBit && lastRep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ChIdle;
      divCnt    <= '0;
      phase     <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      if (!enable) begin
        state  <= ChIdle;
        divCnt <= '0;
        phase  <= 1'b0;
      end else begin
        case (state)
          ChIdle: begin
            state  <= ChRun;
            divCnt <= '0;
            phase  <= 1'b0;
          end
          ChRun: begin
            if (halfEnd) begin
              divCnt <= '0;
              phase  <= ~phase;
              if (stb.finish) begin
                state     <= ChDone;
                phase     <= 1'b0;
                donePulse <= 1'b1;
              end
            end else begin
              divCnt <= divCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/pattern_channel_dp.sv
module pattern_channel_dp
  import pattern_channel_pkg::*;
#(
  parameter int PatW = 64,
  parameter int LenW = 6,
  parameter int RepW = 10,
  parameter int DivW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  chStrobe_t       stb,
  input  logic            polarity,
  input  logic [DivW-1:0] divRatio,
  input  logic [PatW-1:0] pattern,
  input  logic [LenW-1:0] lenM1,
  input  logic [RepW-1:0] repsM1,
  output logic [DivW-1:0] ratioQ,
  output logic            polQ,
  output logic            lastBit,
  output logic            lastRep,
  output logic            curBit
);

  logic [PatW-1:0] patQ;
  logic [LenW-1:0] lenQ;
  logic [RepW-1:0] repsQ;
  logic [LenW-1:0] bitIdx;
  logic [RepW-1:0] repIdx;

  assign lastBit = (bitIdx == lenQ);
  assign lastRep = (repIdx == repsQ);
  assign curBit  = patQ[bitIdx];

  // configuration capture: only on load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polQ   <= 1'b0;
      ratioQ <= '0;
      patQ   <= '0;
      lenQ   <= '0;
      repsQ  <= '0;
    end else if (stb.load) begin
      polQ   <= polarity;
      ratioQ <= divRatio;
      patQ   <= pattern;
      lenQ   <= lenM1;
      repsQ  <= repsM1;
    end
  end

  // bit and repetition position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx <= '0;
      repIdx <= '0;
    end else if (stb.load) begin
      bitIdx <= '0;
      repIdx <= '0;
    end else if (stb.step) begin
      if (lastBit) begin
        bitIdx <= '0;
        repIdx <= repIdx + 1'b1;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pattern_channel.sv
module pattern_channel
  import pattern_channel_pkg::*;
#(
  parameter int WordW    = 32,
  parameter int NumWords = 2,
  parameter int RepW     = 10,
  parameter int DivW     = 32,
  localparam int PatW    = WordW * NumWords,
  localparam int LenW    = $clog2(PatW)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            polarity,
  input  logic [DivW-1:0] divRatio,
  input  logic [PatW-1:0] pattern,
  input  logic [LenW-1:0] lenM1,
  input  logic [RepW-1:0] repsM1,
  output logic            patClk,
  output logic            patData,
  output logic            donePulse
);

  chStrobe_t       stb;
  logic [DivW-1:0] ratioQ;
  logic            polQ;
  logic            lastBit;
  logic            lastRep;
  logic            curBit;
  logic            idle;
  logic            running;
  logic            phase;

  pattern_channel_ctrl #(.DivW(DivW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .ratio     (ratioQ),
    .lastBit   (lastBit),
    .lastRep   (lastRep),
    .stb       (stb),
    .idle      (idle),
    .running   (running),
    .phase     (phase),
    .donePulse (donePulse)
  );

  pattern_channel_dp #(
    .PatW (PatW),
    .LenW (LenW),
    .RepW (RepW),
    .DivW (DivW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .polarity (polarity),
    .divRatio (divRatio),
    .pattern  (pattern),
    .lenM1    (lenM1),
    .repsM1   (repsM1),
    .ratioQ   (ratioQ),
    .polQ     (polQ),
    .lastBit  (lastBit),
    .lastRep  (lastRep),
    .curBit   (curBit)
  );

  // idle follows the live polarity; once enabled the captured one
  assign patClk  = idle ? polarity : (polQ ^ (running & phase));
  assign patData = running & curBit;

endmodule

// File: rtl/pattern_channel_chk.sv
module pattern_channel_chk
  import pattern_channel_pkg::*;
#(
  parameter int DivW = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            enable,
  input logic            patClk,
  input logic            patData,
  input logic            donePulse,
  input logic            running,
  input logic            polQ,
  input logic [DivW-1:0] ratioQ,
  input chStrobe_t       stb
);

  // R9: a cleared enable silences data and done in the next cycle
  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!patData && !donePulse));

  // R7: done is a single-cycle pulse
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R7: done only rises at the end of a running pattern
  assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(donePulse) |-> ($past(running) && !running));

  // R3: data moves only together with the clock at its inactive level
  assert_data_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && (patData != $past(patData))) |-> (patClk == polQ));

  // R8: captured configuration holds while enabled
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !stb.load) |=> ($stable(polQ) && $stable(ratioQ)));

endmodule

bind pattern_channel pattern_channel_chk #(.DivW(DivW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .patClk    (patClk),
  .patData   (patData),
  .donePulse (donePulse),
  .running   (running),
  .polQ      (polQ),
  .ratioQ    (ratioQ),
  .stb       (stb)
);

// File: tb/pattern_channel_bench.sv
module pattern_channel_bench;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        polarity = 1'b0;
  logic [31:0] divRatio = '0;
  logic [63:0] pattern = '0;
  logic [5:0]  lenM1 = '0;
  logic [9:0]  repsM1 = '0;
  logic        patClk;
  logic        patData;
  logic        donePulse;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(ClkPeriod/2) clk = ~clk;

  pattern_channel u_pattern_channel (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .polarity  (polarity),
    .divRatio  (divRatio),
    .pattern   (pattern),
    .lenM1     (lenM1),
    .repsM1    (repsM1),
    .patClk    (patClk),
    .patData   (patData),
    .donePulse (donePulse)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  // one complete run, checked cycle by cycle
  task automatic runPattern(input string tag, input int r, input int len, input int reps,
                            input logic pol, input logic [63:0] pat, input bit scramble);
    int total;
    total = 2 * (len + 1) * (reps + 1) * (r + 1);
    @(negedge clk);
    enable = 1'b1; polarity = pol; divRatio = r; pattern = pat;
    lenM1 = len[5:0]; repsM1 = reps[9:0];
    @(posedge clk);  // load edge
    for (int k = 0; k < total; k++) begin
      int half;
      int bitPos;
      @(negedge clk);
      half   = k / (r + 1);
      bitPos = (half / 2) % (len + 1);
      chk({tag, " R2/R3"}, "patClk", patClk, pol ^ half[0]);
      chk({tag, " R4/R5"}, "patData", patData, pat[bitPos]);
      chk({tag, " R6"}, "donePulse early", donePulse, 1'b0);
      if (scramble && k == 1) begin  // R8: config changes mid-run
        polarity = ~pol; divRatio = r + 5; pattern = ~pat;
        lenM1 = ~len[5:0]; repsM1 = ~reps[9:0];
      end
    end
    @(negedge clk);
    chk({tag, " R7"}, "donePulse", donePulse, 1'b1);
    chk({tag, " R7"}, "patClk at done", patClk, pol);
    chk({tag, " R7"}, "patData at done", patData, 1'b0);
    for (int k = 0; k < 4; k++) begin  // R10: enable stays high, no restart
      @(negedge clk);
      chk({tag, " R10"}, "donePulse after", donePulse, 1'b0);
      chk({tag, " R10"}, "patClk after", patClk, pol);
      chk({tag, " R10"}, "patData after", patData, 1'b0);
    end
    polarity = pol;
    enable = 1'b0;
    @(negedge clk);
    chk({tag, " R9"}, "idle patClk", patClk, pol);
  endtask

  initial begin
    int lens[6] = '{0, 1, 2, 31, 32, 63};
    int seed;
    seed = 1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "patClk", patClk, 1'b0);
    chk("R1", "patData", patData, 1'b0);
    chk("R1", "donePulse", donePulse, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "patClk after release", patClk, 1'b0);

    // main sweep: R2..R7, R10
    for (int r = 0; r < 3; r++)
      for (int li = 0; li < 6; li++)
        for (int rp = 0; rp < 3; rp++)
          for (int p = 0; p < 2; p++) begin
            logic [63:0] pat;
            seed = seed * 1103515245 + 12345;
            pat = {seed[31:0] ^ 32'h9e37_79b9, seed[30:0] ^ (seed[31:0] >> 7), 1'b1 ^ seed[3]};
            runPattern("sweep", r, lens[li], rp, p[0], pat, 1'b0);
          end

    // R4: word boundary with a sparse pattern
    runPattern("R4 boundary", 0, 63, 0, 1'b0, 64'h0000_0001_8000_0000, 1'b0);
    // R5: full length, R6: maximum repetition count
    runPattern("R5 full", 1, 63, 1, 1'b1, 64'hf0e1_d2c3_b4a5_9687, 1'b0);
    runPattern("R6 max reps", 0, 0, 1023, 1'b0, 64'h1, 1'b0);
    // R8: scrambled configuration while enabled
    runPattern("R8 frozen", 2, 5, 2, 1'b0, 64'h0000_0000_0000_002d, 1'b1);
    runPattern("R8 frozen pol1", 1, 33, 1, 1'b1, 64'h5a5a_0f0f_3c3c_a5a5, 1'b1);

    // R9: abort mid-run
    @(negedge clk);
    enable = 1'b1; polarity = 1'b1; divRatio = 1; pattern = '1; lenM1 = 6'd7; repsM1 = 10'd3;
    repeat (11) @(negedge clk);
    enable = 1'b0; polarity = 1'b0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      chk("R9", "patData after abort", patData, 1'b0);
      chk("R9", "patClk after abort", patClk, 1'b0);
      chk("R9", "donePulse after abort", donePulse, 1'b0);
    end
    // fresh run after abort restarts from bit 0
    runPattern("R9 rerun", 0, 3, 0, 1'b0, 64'h6, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(ClkPeriod * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule